// File: doc/BRIEF.md
# Keyed Banked GPIO Register Block

This block holds the data and direction state for a parameterised number of 32-pin GPIO banks, from one to eight. Software reaches it through a plain 32-bit register bus with separate read and write strobes. Each pin has a direction bit in its own control word. Pin outputs change only through write-one-to-set and write-one-to-clear words. The latched drive value and the synchronised pin inputs can both be read back per bank.

Every bank starts out locked. A locked bank drops all state-changing writes. To open or close a bank, software first writes a fixed key to a global key word. The very next bus write must then place a code in that bank's lock word. Any other write in between cancels the key. Reads are always allowed and never cancel a pending key.

Top module: `keyed_gpio_banks`

## Requirements
- R1: After reset every bank reads locked (lock word 0xFFFFFFFF), every pin is an input (control bit 0 reads 1, output enable low) and every output latch is 0.
- R2: On an unlocked bank, writing the set word (0x040 + 4*bank) drives high each output pin whose data bit is 1. Writing the clear word (0x060 + 4*bank) drives low each output pin whose data bit is 1. Pins whose data bit is 0 keep their value. The output status word (0x000 + 4*bank) reads back the latch.
- R3: Set and clear writes leave the latch bit of a pin configured as input unchanged.
- R4: The control word of global pin p sits at 0x100 + 4*p, with bank = p[7:5] and bit = p[4:0]. Its bit 0 is the direction: 1 means input and 0 means output. The pin's output enable is the inverse of that bit, and the bit reads back in bit 0.
- R5: Writing key 0x00A5A501 to 0x520 and then code 0x00000000 to the bank's lock word (0x500 + 4*bank) unlocks the bank. An unlocked bank's lock word reads 0x00000000.
- R6: The same sequence with code 0xFFFFFFFF locks the bank. Any other code leaves the lock state unchanged.
- R7: A lock word write counts only if the previous bus write was the correct key. A wrong key or any other intervening write cancels the pending key. Reads do not cancel it.
- R8: While a bank is locked, writes to its set, clear and control words have no effect, and its status and control words remain readable.
- R9: Each input pin passes through two flip-flops. The input status word (0x020 + 4*bank) shows a pin change on a read issued two cycles after the change, and not on the two reads before it.
- R10: Banks are independent. Addresses of banks at or beyond the bank count, unmapped addresses, and addresses with nonzero low two bits read 0 and ignore writes.
- R11: Read data appears on the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| pin_in_i | input | 32*NUM_BANKS | Pin input levels, asynchronous |
| pin_out_o | output | 32*NUM_BANKS | Pin output latch values |
| pin_oe_o | output | 32*NUM_BANKS | Pin output enables, high for output |

## Verification
The hardest cases to reach are the ones where the key sequence is almost right. Examples are a key followed by a stray data write, a key with one bit wrong, and a valid key followed by a code that is neither open nor shut. In each case the lock state must not move. The bench builds each of these near misses back to back and reads the lock word after each one. It also places a read between the key and the code, to show that reads leave the pending key alone. Pins are switched back to input while their latch holds 1, so the set/clear mask is tested on a pin that could visibly change.

// File: rtl/kgb_pkg.sv
package kgb_pkg;
  typedef enum logic [2:0] {
    RK_NONE, RK_OUT_ST, RK_IN_ST, RK_SET, RK_CLR, RK_CTRL, RK_LOCK, RK_KEY
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [2:0] bank;
    logic [4:0] bit_idx;
  } reg_sel_t;

  localparam int unsigned PINS_PER_BANK = 32;
  localparam logic [31:0] KEY_VALUE = 32'h00A5A501;
  localparam logic [31:0] CODE_OPEN = 32'h0000_0000;
  localparam logic [31:0] CODE_SHUT = 32'hFFFF_FFFF;

  // word offsets (byte offset / 4)
  localparam int unsigned WO_OUT_ST = 0;
  localparam int unsigned WO_IN_ST  = 8;
  localparam int unsigned WO_SET    = 16;
  localparam int unsigned WO_CLR    = 24;
  localparam int unsigned WO_CTRL   = 64;
  localparam int unsigned WO_LOCK   = 320;
  localparam int unsigned WO_KEY    = 328;
endpackage

// File: rtl/kgb_decode.sv
module kgb_decode
  import kgb_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_t          sel_o
);
  localparam int WA_W = ADDR_W - 2;

  logic [WA_W-1:0] wa;
  int unsigned     wa_u;
  logic [7:0]      pin8;
  reg_sel_t        raw;

  always_comb begin
    wa   = addr_i[ADDR_W-1:2];
    wa_u = 32'(wa);
    pin8 = 8'(wa_u - WO_CTRL);
    raw  = '{kind: RK_NONE, bank: 3'd0, bit_idx: 5'd0};
    if (wa_u < WO_IN_ST) begin
      raw.kind = RK_OUT_ST;
      raw.bank = 3'(wa_u - WO_OUT_ST);
    end else if (wa_u < WO_SET) begin
      raw.kind = RK_IN_ST;
      raw.bank = 3'(wa_u - WO_IN_ST);
    end else if (wa_u < WO_CLR) begin
      raw.kind = RK_SET;
      raw.bank = 3'(wa_u - WO_SET);
    end else if (wa_u < WO_CLR + 8) begin
      raw.kind = RK_CLR;
      raw.bank = 3'(wa_u - WO_CLR);
    end else if (wa_u >= WO_CTRL && wa_u < WO_LOCK) begin
      raw.kind    = RK_CTRL;
      raw.bank    = pin8[7:5];
      raw.bit_idx = pin8[4:0];
    end else if (wa_u >= WO_LOCK && wa_u < WO_KEY) begin
      raw.kind = RK_LOCK;
      raw.bank = 3'(wa_u - WO_LOCK);
    end else if (wa_u == WO_KEY) begin
      raw.kind = RK_KEY;
    end

    sel_o = raw;
    if (addr_i[1:0] != 2'b00) begin
      sel_o.kind = RK_NONE;
    end else if (raw.kind != RK_KEY && raw.kind != RK_NONE &&
                 32'(raw.bank) >= NUM_BANKS) begin
      sel_o.kind = RK_NONE;
    end
  end
endmodule

// File: rtl/kgb_lock.sv
module kgb_lock
  import kgb_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  reg_kind_e            kind_i,
  input  logic [2:0]           bank_i,
  input  logic [31:0]          wdata_i,
  output logic [NUM_BANKS-1:0] unlocked_o
);
  logic pend_q, pend_d, pend_en;
  logic code_hit;
  logic code_known;

  always_comb begin
    pend_en    = wr_i;
    pend_d     = (kind_i == RK_KEY) && (wdata_i == KEY_VALUE);
    code_hit   = wr_i && (kind_i == RK_LOCK) && pend_q;
    code_known = (wdata_i == CODE_OPEN) || (wdata_i == CODE_SHUT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_lock
    logic open_q, open_d, open_en;

    always_comb begin
      open_en = code_hit && (bank_i == 3'(b)) && code_known;
      open_d  = (wdata_i == CODE_OPEN);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q <= 1'b0;
      end else if (open_en) begin
        open_q <= open_d;
      end
    end

    assign unlocked_o[b] = open_q;

    // R5: a bank only opens right after an accepted key
    p_open_needs_key_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(unlocked_o[b]) |-> $past(pend_q));

    // R7: a lock write with no pending key leaves the state alone
    p_stray_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && kind_i == RK_LOCK && !pend_q) |=> $stable(unlocked_o[b]));
  end

  // R7: any write that is not the right key drops the pending key
  p_key_cancel_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !(kind_i == RK_KEY && wdata_i == KEY_VALUE)) |=> !pend_q);
endmodule

// File: rtl/kgb_pin_bank.sv
module kgb_pin_bank #(
  parameter int PINS = 32,
  localparam int BIT_W = $clog2(PINS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             unlocked_i,
  input  logic             wr_set_i,
  input  logic             wr_clr_i,
  input  logic             wr_ctrl_i,
  input  logic [BIT_W-1:0] bit_idx_i,
  input  logic [31:0]      wdata_i,
  input  logic [PINS-1:0]  pin_in_i,
  output logic [PINS-1:0]  out_q_o,
  output logic [PINS-1:0]  dir_q_o,
  output logic [PINS-1:0]  in_sync_o,
  output logic [PINS-1:0]  pin_oe_o
);
  logic [PINS-1:0] out_q, out_d, dir_q, dir_d;
  logic [PINS-1:0] sync1_q, sync2_q;
  logic [PINS-1:0] drive_mask;
  logic            upd_en;

  always_comb begin
    drive_mask = wdata_i[PINS-1:0] & ~dir_q;
    upd_en     = unlocked_i && (wr_set_i || wr_clr_i || wr_ctrl_i);
    out_d      = out_q;
    dir_d      = dir_q;
    if (wr_set_i) out_d = out_q | drive_mask;
    if (wr_clr_i) out_d = out_q & ~drive_mask;
    if (wr_ctrl_i) dir_d[bit_idx_i] = wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '1;
    end else if (upd_en) begin
      out_q <= out_d;
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in_i;
      sync2_q <= sync1_q;
    end
  end

  assign out_q_o   = out_q;
  assign dir_q_o   = dir_q;
  assign in_sync_o = sync2_q;
  assign pin_oe_o  = ~dir_q;

  // cycles-since-reset counter for the synchroniser check
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_q <= 2'd0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R8: a locked bank keeps its latch and direction
  p_locked_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unlocked_i |=> ($stable(out_q) && $stable(dir_q)));

  // R3: latch bits of input pins never change (direction taken before the edge)
  p_input_pin_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((out_q ^ $past(out_q)) & $past(dir_q)) == '0);

  // R9: status equals the pins two edges back
  p_sync_delay_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) |-> (in_sync_o == $past(pin_in_i, 2)));
endmodule

// File: rtl/keyed_gpio_banks.sv
module keyed_gpio_banks
  import kgb_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 12,
  localparam int NPIN     = NUM_BANKS * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic [NPIN-1:0]   pin_in_i,
  output logic [NPIN-1:0]   pin_out_o,
  output logic [NPIN-1:0]   pin_oe_o
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  reg_sel_t             sel;
  logic [NUM_BANKS-1:0] unlocked;
  logic [31:0]          out_st  [NUM_BANKS];
  logic [31:0]          dir_st  [NUM_BANKS];
  logic [31:0]          in_st   [NUM_BANKS];
  logic [BANK_W-1:0]    bidx;

  kgb_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) u_decode (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  kgb_lock #(.NUM_BANKS(NUM_BANKS)) u_lock (
    .clk_i      (clk),
    .rst_ni     (rst_sync_q),
    .wr_i       (bus_wr_i),
    .kind_i     (sel.kind),
    .bank_i     (sel.bank),
    .wdata_i    (bus_wdata_i),
    .unlocked_o (unlocked)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic hit;
    assign hit = bus_wr_i && (sel.bank == 3'(b));

    kgb_pin_bank #(.PINS(32)) u_bank (
      .clk_i      (clk),
      .rst_ni     (rst_sync_q),
      .unlocked_i (unlocked[b]),
      .wr_set_i   (hit && sel.kind == RK_SET),
      .wr_clr_i   (hit && sel.kind == RK_CLR),
      .wr_ctrl_i  (hit && sel.kind == RK_CTRL),
      .bit_idx_i  (sel.bit_idx),
      .wdata_i    (bus_wdata_i),
      .pin_in_i   (pin_in_i[b*32 +: 32]),
      .out_q_o    (out_st[b]),
      .dir_q_o    (dir_st[b]),
      .in_sync_o  (in_st[b]),
      .pin_oe_o   (pin_oe_o[b*32 +: 32])
    );

    assign pin_out_o[b*32 +: 32] = out_st[b];
  end

  // read path
  logic [31:0] rdata_d, rdata_q;
  always_comb begin
    bidx    = sel.bank[BANK_W-1:0];
    rdata_d = '0;
    unique case (sel.kind)
      RK_OUT_ST: rdata_d = out_st[bidx];
      RK_IN_ST:  rdata_d = in_st[bidx];
      RK_CTRL:   rdata_d = {31'd0, dir_st[bidx][sel.bit_idx]};
      RK_LOCK:   rdata_d = unlocked[bidx] ? CODE_OPEN : CODE_SHUT;
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      rdata_q <= '0;
    end else if (bus_rd_i) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata_o = rdata_q;

  // R11: read data only moves on a read strobe
  p_read_hold_r11: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !bus_rd_i |=> $stable(bus_rdata_o));

  // R4: a bank's drive enables only change while it is open
  p_oe_needs_open_r4: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (unlocked == '0) |=> $stable(pin_oe_o));
endmodule

// File: tb/keyed_gpio_banks_tb_top.sv
`timescale 1ns/1ps
module keyed_gpio_banks_tb_top;
  localparam int NB   = 2;
  localparam int NPIN = NB * 32;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            bus_wr, bus_rd;
  logic [11:0]     bus_addr;
  logic [31:0]     bus_wdata;
  logic [31:0]     bus_rdata;
  logic [NPIN-1:0] pin_in, pin_out, pin_oe;

  int checks   = 0;
  int failures = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  keyed_gpio_banks #(.NUM_BANKS(NB), .ADDR_W(12)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr),
    .bus_rd_i    (bus_rd),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .pin_in_i    (pin_in),
    .pin_out_o   (pin_out),
    .pin_oe_o    (pin_oe)
  );

  function automatic logic [11:0] a_out(int b);  return 12'(32'h000 + 4*b); endfunction
  function automatic logic [11:0] a_in(int b);   return 12'(32'h020 + 4*b); endfunction
  function automatic logic [11:0] a_set(int b);  return 12'(32'h040 + 4*b); endfunction
  function automatic logic [11:0] a_clr(int b);  return 12'(32'h060 + 4*b); endfunction
  function automatic logic [11:0] a_ctl(int p);  return 12'(32'h100 + 4*p); endfunction
  function automatic logic [11:0] a_lock(int b); return 12'(32'h500 + 4*b); endfunction
  localparam logic [11:0] A_KEY = 12'h520;
  localparam logic [31:0] KEY   = 32'h00A5A501;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver tasks: called at a falling edge, return at the next falling edge
  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic unlock_key(int b, logic [31:0] code);
    wr(A_KEY, KEY);
    wr(a_lock(b), code);
  endtask

  // monitor: scoreboard compare one step after the capturing edge
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd === 1'b1) begin
        #1;
        if (exp_q.size() == 0) begin
          checks++; failures++;
          $display("FAIL R11 actual=unexpected read expected=queued item");
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, {32'd0, bus_rdata}, {32'd0, e});
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; pin_in = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 oe", {'0, pin_oe}, 64'd0);
    chk("R1 out", {'0, pin_out}, 64'd0);
    rd(a_lock(0), 32'hFFFF_FFFF, "R1 lock0");
    rd(a_ctl(5), 32'd1, "R1 ctrl5");

    // R8 locked bank ignores control write
    wr(a_ctl(3), 32'd0);
    rd(a_ctl(3), 32'd1, "R8 ctrl locked");
    chk("R8 oe locked", {'0, pin_oe}, 64'd0);

    // R5 unlock bank 0
    unlock_key(0, 32'h0);
    rd(a_lock(0), 32'h0, "R5 open0");
    rd(a_lock(1), 32'hFFFF_FFFF, "R10 bank1 still locked");

    // R4 pins 0..7 to output
    for (int p = 0; p < 8; p++) wr(a_ctl(p), 32'd0);
    chk("R4 oe", {'0, pin_oe}, 64'h0000_0000_0000_00FF);
    rd(a_ctl(2), 32'd0, "R4 ctrl2 readback");

    // R2/R3 set including input pin 8
    wr(a_set(0), 32'h0000_01A5);
    chk("R2 R3 set", {'0, pin_out}, 64'h0000_0000_0000_00A5);
    rd(a_out(0), 32'h0000_00A5, "R2 outst0");
    wr(a_clr(0), 32'h0000_0021);
    chk("R2 clr", {'0, pin_out}, 64'h0000_0000_0000_0084);

    // R3 pin 2 back to input while latch holds 1
    wr(a_ctl(2), 32'd1);
    chk("R4 oe after flip", {'0, pin_oe}, 64'h0000_0000_0000_00FB);
    wr(a_clr(0), 32'h0000_0084);
    chk("R3 clr input pin", {'0, pin_out}, 64'h0000_0000_0000_0004);

    // R7 key cancelled by an intervening write
    wr(A_KEY, KEY);
    wr(a_set(0), 32'h1);
    wr(a_lock(0), 32'hFFFF_FFFF);
    rd(a_lock(0), 32'h0, "R7 cancelled key");
    chk("R2 set bit0", {'0, pin_out}, 64'h0000_0000_0000_0005);

    // R7 wrong key
    wr(A_KEY, 32'h00A5A500);
    wr(a_lock(0), 32'hFFFF_FFFF);
    rd(a_lock(0), 32'h0, "R7 wrong key");

    // R6 unknown code
    unlock_key(0, 32'h1234_5678);
    rd(a_lock(0), 32'h0, "R6 odd code");

    // R6 lock, then R8 writes dropped
    unlock_key(0, 32'hFFFF_FFFF);
    rd(a_lock(0), 32'hFFFF_FFFF, "R6 shut0");
    wr(a_set(0), 32'h0000_00F0);
    wr(a_clr(0), 32'h0000_0005);
    wr(a_ctl(0), 32'd1);
    chk("R8 out frozen", {'0, pin_out}, 64'h0000_0000_0000_0005);
    chk("R8 oe frozen", {'0, pin_oe}, 64'h0000_0000_0000_00FB);
    rd(a_out(0), 32'h0000_0005, "R8 read while locked");

    // R7 lock write with no key
    wr(a_lock(0), 32'h0);
    rd(a_lock(0), 32'hFFFF_FFFF, "R7 no key");

    // R7 read between key and code keeps the key; R10 bank1
    wr(A_KEY, KEY);
    rd(a_out(0), 32'h0000_0005, "R11 read between");
    wr(a_lock(1), 32'h0);
    rd(a_lock(1), 32'h0, "R7 read keeps key");
    wr(a_ctl(40), 32'd0);
    wr(a_set(1), 32'h0000_0100);
    chk("R10 bank1 pin40", {'0, pin_out}, 64'h0000_0100_0000_0005);
    rd(a_out(1), 32'h0000_0100, "R10 outst1");

    // R10 out-of-range bank and misaligned address
    wr(a_set(2), 32'hFFFF_FFFF);
    rd(a_out(2), 32'h0, "R10 bank2 read");
    rd(a_ctl(70), 32'h0, "R10 ctrl bank2");
    wr(12'h045, 32'hFFFF_FFFF);
    chk("R10 misaligned write", {'0, pin_out}, 64'h0000_0100_0000_0005);
    rd(12'h001, 32'h0, "R10 misaligned read");

    // R9 synchroniser: change and three back-to-back reads
    pin_in = 64'h0000_0002_0000_0000;
    rd(a_in(1), 32'h0, "R9 first read");
    rd(a_in(1), 32'h0, "R9 second read");
    rd(a_in(1), 32'h2, "R9 third read");
    pin_in = 64'h0000_0002_8000_0000;
    repeat (3) @(negedge clk);
    rd(a_in(0), 32'h8000_0000, "R9 bank0");
    chk("R11 rdata held", {32'd0, bus_rdata}, 64'h8000_0000);

    repeat (3) @(negedge clk);
    chk("R11 queue drained", 64'(exp_q.size()), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule